// File: doc/BRIEF.md
# Debug Mailbox Between a Register Bus and a JTAG Port

This block is a small memory-mapped peripheral that lets on-chip software and an external debugger exchange 32-bit words. Software writes an outbound word over the register bus. The debugger picks that word up through its scan chain, and the mailbox records that the pickup happened. In the other direction, the debugger deposits an inbound word, and software reads it over the bus. The JTAG side is not modelled here. Its events arrive as single-cycle pulses that are already synchronized to the bus clock: one pulse marks a finished capture of the outbound word, and one pulse marks an update that carries a new inbound word.

Each direction has a ready flag and a sticky interrupt flag. The ready flags tell each side whether the mailbox slot is occupied. The interrupt flags stay set until software writes ones to clear them. Each interrupt flag drives a registered interrupt output through its own enable bit. The outbound word and both ready flags are exported toward the scan-chain logic, so the debugger can poll them.

A typical use is streaming a memory buffer out to a debugger. Software writes one element and waits for the outbound interrupt that follows the debugger's read. It then clears that interrupt and writes the next element.

Top module: `dbg_mailbox`

## Requirements
- R1: After a synchronous reset, every register reads 0, and `jt_tx_word`, `jt_tx_rdy`, `jt_rx_rdy`, `irq_tx` and `irq_rx` are 0.
- R2: Register indices on `bus_addr` are as follows. Index 0 is control: bit0 enables the transmit interrupt and bit1 enables the receive interrupt. Index 1 is flags. Index 2 is the transmit word, which can be read and written. Index 3 is the receive word, which is read-only. Unused bits and indices 4 to 15 read 0. Writes to indices 4 to 15 and to index 3 change nothing.
- R3: Flags bit1 (transmit ready) sets on a completed write to index 2 and clears on a `jt_capture_done` pulse. The transmit word appears on `jt_tx_word`, and bit1 appears on `jt_tx_rdy`.
- R4: Flags bit0 (transmit interrupt) sets on a `jt_capture_done` pulse that arrives while transmit ready is 1. A capture pulse that arrives while transmit ready is 0 leaves bit0 unchanged.
- R5: A `jt_update` pulse loads `jt_rx_word` into the receive word. The same pulse sets flags bit3 (receive ready, exported on `jt_rx_rdy`) and flags bit2 (receive interrupt).
- R6: Receive ready clears only on a completed read of index 3, meaning a cycle in which `bus_req` and `bus_ack` are both high. A request that is dropped before that cycle leaves receive ready unchanged.
- R7: Writing 1 to flags bit0 clears the transmit interrupt, and writing 1 to flags bit2 clears the receive interrupt. Zeros have no effect. Bits 1 and 3 are read-only.
- R8: When a flag's set event and its clear event land in the same cycle, the set wins. This holds for both ready flags and both interrupt flags.
- R9: `irq_tx` equals transmit interrupt AND control bit0, delayed by one clock. `irq_rx` equals receive interrupt AND control bit1, delayed by one clock.
- R10: `bus_ack` is a one-cycle pulse in the cycle after `bus_req` is first seen high. `bus_rdata` is valid while `bus_ack` is high. The requester holds its request until it sees `bus_ack`, and the transfer takes effect at the end of the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Transfer request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register index |
| bus_wdata | input | DW | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | DW | Read data, valid with `bus_ack` |
| jt_capture_done | input | 1 | Pulse: debugger finished capturing the transmit word |
| jt_update | input | 1 | Pulse: new receive word present on `jt_rx_word` |
| jt_rx_word | input | DW | Inbound word from the scan chain |
| jt_tx_word | output | DW | Outbound word toward the scan chain |
| jt_tx_rdy | output | 1 | Transmit ready flag |
| jt_rx_rdy | output | 1 | Receive ready flag |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The hardest situations to reach are the collisions. In these, a JTAG-side pulse lands in exactly the cycle where a bus transfer completes: a capture during a transmit-word write, a capture during a write-one-to-clear, and an update during a receive-word read or during an interrupt clear. The bus task can raise either pulse in the acknowledge cycle, so the set-wins rule is exercised for each flag. The same task can also drop the request after the acknowledge appears, which produces the aborted read that must leave receive ready set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_REGS = 4;

  // register indices on the bus
  localparam int IDX_CTRL  = 0;
  localparam int IDX_FLAGS = 1;
  localparam int IDX_TXW   = 2;
  localparam int IDX_RXW   = 3;

  // flag bit positions
  localparam int FLG_TX_INT = 0;
  localparam int FLG_TX_RDY = 1;
  localparam int FLG_RX_INT = 2;
  localparam int FLG_RX_RDY = 3;

  // control bit positions
  localparam int CFG_TX_IEN = 0;
  localparam int CFG_RX_IEN = 1;
endpackage

// File: rtl/mbx_bus_port.sv
module mbx_bus_port #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int NR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NR*DW-1:0] rd_flat,
  output logic             bus_ack,
  output logic [DW-1:0]    bus_rdata,
  output logic [NR-1:0]    wr_hit,
  output logic [NR-1:0]    rd_hit
);
  logic          ack_q;
  logic [DW-1:0] rdata_q;
  logic [NR-1:0] sel;
  logic [DW-1:0] rd_mux;
  logic          done;
  logic          issue;

  assign issue = bus_req && !ack_q;
  assign done  = bus_req && ack_q;

  for (genvar i = 0; i < NR; i++) begin : g_dec
    assign sel[i]    = (bus_addr == AW'(i));
    assign wr_hit[i] = done && bus_we && sel[i];
    assign rd_hit[i] = done && !bus_we && sel[i];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NR; i++) begin
      if (sel[i]) rd_mux = rd_flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= issue;
      if (issue) rdata_q <= rd_mux;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/mbx_flag_pair.sv
module mbx_flag_pair (
  input  logic clk,
  input  logic rst,
  input  logic rdy_set,
  input  logic rdy_clr,
  input  logic int_set,
  input  logic int_clr,
  output logic rdy_q,
  output logic int_q
);
  // set has priority over clear on both flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      if (rdy_set)      rdy_q <= 1'b1;
      else if (rdy_clr) rdy_q <= 1'b0;
      if (int_set)      int_q <= 1'b1;
      else if (int_clr) int_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbx_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ack,
  output logic [DW-1:0] bus_rdata,
  input  logic          jt_capture_done,
  input  logic          jt_update,
  input  logic [DW-1:0] jt_rx_word,
  output logic [DW-1:0] jt_tx_word,
  output logic          jt_tx_rdy,
  output logic          jt_rx_rdy,
  output logic          irq_tx,
  output logic          irq_rx
);
  localparam int NR = NUM_REGS;

  logic [NR-1:0]    wr_hit;
  logic [NR-1:0]    rd_hit;
  logic [NR*DW-1:0] rd_flat;

  logic          tx_ien_q, rx_ien_q;
  logic [DW-1:0] tx_word_q, rx_word_q;
  logic          tx_rdy_q, tx_int_q, rx_rdy_q, rx_int_q;
  logic          irq_tx_q, irq_rx_q;

  logic          tx_wr_stb, rx_rd_stb, flg_wr_stb;
  logic [DW-1:0] ctrl_view, flag_view;

  assign tx_wr_stb  = wr_hit[IDX_TXW];
  assign rx_rd_stb  = rd_hit[IDX_RXW];
  assign flg_wr_stb = wr_hit[IDX_FLAGS];

  mbx_bus_port #(.AW(AW), .DW(DW), .NR(NR)) u_port (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .rd_flat(rd_flat),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  // outbound direction
  mbx_flag_pair u_tx_flags (
    .clk(clk), .rst(rst),
    .rdy_set(tx_wr_stb),
    .rdy_clr(jt_capture_done),
    .int_set(jt_capture_done && tx_rdy_q),
    .int_clr(flg_wr_stb && bus_wdata[FLG_TX_INT]),
    .rdy_q(tx_rdy_q), .int_q(tx_int_q)
  );

  // inbound direction
  mbx_flag_pair u_rx_flags (
    .clk(clk), .rst(rst),
    .rdy_set(jt_update),
    .rdy_clr(rx_rd_stb),
    .int_set(jt_update),
    .int_clr(flg_wr_stb && bus_wdata[FLG_RX_INT]),
    .rdy_q(rx_rdy_q), .int_q(rx_int_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ien_q  <= 1'b0;
      rx_ien_q  <= 1'b0;
      tx_word_q <= '0;
      rx_word_q <= '0;
      irq_tx_q  <= 1'b0;
      irq_rx_q  <= 1'b0;
    end else begin
      if (wr_hit[IDX_CTRL]) begin
        tx_ien_q <= bus_wdata[CFG_TX_IEN];
        rx_ien_q <= bus_wdata[CFG_RX_IEN];
      end
      if (tx_wr_stb) tx_word_q <= bus_wdata;
      if (jt_update) rx_word_q <= jt_rx_word;
      irq_tx_q <= tx_int_q && tx_ien_q;
      irq_rx_q <= rx_int_q && rx_ien_q;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CFG_TX_IEN] = tx_ien_q;
    ctrl_view[CFG_RX_IEN] = rx_ien_q;
    flag_view = '0;
    flag_view[FLG_TX_INT] = tx_int_q;
    flag_view[FLG_TX_RDY] = tx_rdy_q;
    flag_view[FLG_RX_INT] = rx_int_q;
    flag_view[FLG_RX_RDY] = rx_rdy_q;
  end

  assign rd_flat = {rx_word_q, tx_word_q, flag_view, ctrl_view};

  assign jt_tx_word = tx_word_q;
  assign jt_tx_rdy  = tx_rdy_q;
  assign jt_rx_rdy  = rx_rdy_q;
  assign irq_tx     = irq_tx_q;
  assign irq_rx     = irq_rx_q;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          jt_capture_done,
  input logic          jt_update,
  input logic [DW-1:0] jt_rx_word,
  input logic          jt_tx_rdy,
  input logic          jt_rx_rdy,
  input logic          irq_tx,
  input logic          tx_wr_stb,
  input logic          rx_rd_stb,
  input logic          tx_int_q,
  input logic          tx_ien_q,
  input logic [DW-1:0] rx_word_q
);
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  assert_ack_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req));

  assert_tx_rdy_set_R3: assert property (@(posedge clk) disable iff (rst)
    tx_wr_stb |=> jt_tx_rdy);

  assert_tx_rdy_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (jt_capture_done && !tx_wr_stb) |=> !jt_tx_rdy);

  assert_tx_int_set_R4: assert property (@(posedge clk) disable iff (rst)
    (jt_capture_done && jt_tx_rdy) |=> tx_int_q);

  assert_rx_load_R5: assert property (@(posedge clk) disable iff (rst)
    jt_update |=> (jt_rx_rdy && rx_word_q == $past(jt_rx_word)));

  assert_rx_rdy_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (jt_rx_rdy && !rx_rd_stb) |=> jt_rx_rdy);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> $past(tx_ien_q));
endmodule

bind dbg_mailbox mbx_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .bus_req(bus_req), .bus_ack(bus_ack),
  .jt_capture_done(jt_capture_done), .jt_update(jt_update),
  .jt_rx_word(jt_rx_word),
  .jt_tx_rdy(jt_tx_rdy), .jt_rx_rdy(jt_rx_rdy),
  .irq_tx(irq_tx),
  .tx_wr_stb(tx_wr_stb), .rx_rd_stb(rx_rd_stb),
  .tx_int_q(tx_int_q), .tx_ien_q(tx_ien_q),
  .rx_word_q(rx_word_q)
);

// File: tb/dbg_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_mailbox_tb;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ack;
  logic [DW-1:0] bus_rdata;
  logic          jt_capture_done = 1'b0;
  logic          jt_update = 1'b0;
  logic [DW-1:0] jt_rx_word = '0;
  logic [DW-1:0] jt_tx_word;
  logic          jt_tx_rdy, jt_rx_rdy, irq_tx, irq_rx;

  int n_vec = 0;
  int n_bad = 0;
  logic [DW-1:0] rd_val;
  logic ack_seen;

  always #2 clk = ~clk;

  dbg_mailbox #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .jt_capture_done(jt_capture_done), .jt_update(jt_update),
    .jt_rx_word(jt_rx_word), .jt_tx_word(jt_tx_word),
    .jt_tx_rdy(jt_tx_rdy), .jt_rx_rdy(jt_rx_rdy),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bus transfer; optional JTAG pulse in the acknowledge cycle; optional abort
  task automatic xfer(input logic we, input int idx, input logic [DW-1:0] wd,
                      input logic p_upd, input logic p_cap, input logic abort);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = AW'(idx); bus_wdata = wd;
    @(negedge clk);
    ack_seen = bus_ack;
    rd_val = bus_rdata;
    if (abort) bus_req = 1'b0;
    jt_update = p_upd;
    jt_capture_done = p_cap;
    @(negedge clk);
    bus_req = 1'b0; jt_update = 1'b0; jt_capture_done = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] wd);
    xfer(1'b1, idx, wd, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input int idx);
    xfer(1'b0, idx, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic pulse_cap();
    @(negedge clk); jt_capture_done = 1'b1;
    @(negedge clk); jt_capture_done = 1'b0;
  endtask

  task automatic pulse_upd(input logic [DW-1:0] w);
    @(negedge clk); jt_update = 1'b1; jt_rx_word = w;
    @(negedge clk); jt_update = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      rd(i);
      chk("R1 register after reset", rd_val, '0);
    end
    chk("R1 jt_tx_word", jt_tx_word, '0);
    chk("R1 ready/irq outputs", {28'd0, jt_tx_rdy, jt_rx_rdy, irq_tx, irq_rx}, '0);
  endtask

  task automatic t_handshake();
    rd(0);
    chk("R10 ack with read data", {31'd0, ack_seen}, 32'd1);
    chk("R10 ack is one cycle", {31'd0, bus_ack}, 32'd0);
  endtask

  task automatic t_map();
    wr(0, 32'hFFFF_FFFF);
    rd(0);
    chk("R2 control unused bits", rd_val, 32'h3);
    wr(0, 32'h0);
    wr(9, 32'h1234_5678);
    rd(9);
    chk("R2 unmapped index", rd_val, '0);
    wr(3, 32'hDEAD_BEEF);
    rd(3);
    chk("R2 receive word read-only", rd_val, '0);
    rd(1);
    chk("R2 flags untouched", rd_val, '0);
  endtask

  task automatic t_tx_path();
    wr(0, 32'h1);
    wr(2, 32'hA5A5_0001);
    chk("R3 jt_tx_word", jt_tx_word, 32'hA5A5_0001);
    chk("R3 jt_tx_rdy set", {31'd0, jt_tx_rdy}, 32'd1);
    rd(2);
    chk("R2 transmit word readback", rd_val, 32'hA5A5_0001);
    wr(1, 32'hA);
    rd(1);
    chk("R7 ready bits read-only", rd_val, 32'h2);
    pulse_cap();
    chk("R3 jt_tx_rdy cleared", {31'd0, jt_tx_rdy}, 32'd0);
    chk("R9 irq_tx one cycle late", {31'd0, irq_tx}, 32'd0);
    wait_cyc(1);
    chk("R9 irq_tx asserted", {31'd0, irq_tx}, 32'd1);
    rd(1);
    chk("R4 transmit interrupt set", rd_val, 32'h1);
    wr(1, 32'h1);
    rd(1);
    chk("R7 transmit interrupt cleared", rd_val, 32'h0);
    chk("R9 irq_tx dropped", {31'd0, irq_tx}, 32'd0);
    pulse_cap();
    rd(1);
    chk("R4 capture while not ready", rd_val, 32'h0);
  endtask

  task automatic t_gate();
    wr(0, 32'h0);
    wr(2, 32'h0000_0042);
    pulse_cap();
    wait_cyc(2);
    chk("R9 irq_tx gated off", {31'd0, irq_tx}, 32'd0);
    rd(1);
    chk("R4 flag set while gated", rd_val, 32'h1);
    wr(0, 32'h1);
    wait_cyc(1);
    chk("R9 irq_tx after enable", {31'd0, irq_tx}, 32'd1);
    wr(1, 32'h1);
    wr(0, 32'h0);
  endtask

  task automatic t_rx_path();
    wr(0, 32'h2);
    pulse_upd(32'h1357_9BDF);
    chk("R5 jt_rx_rdy set", {31'd0, jt_rx_rdy}, 32'd1);
    wait_cyc(1);
    chk("R9 irq_rx asserted", {31'd0, irq_rx}, 32'd1);
    rd(1);
    chk("R5 receive flags", rd_val, 32'hC);
    xfer(1'b0, 3, '0, 1'b0, 1'b0, 1'b1);
    rd(1);
    chk("R6 aborted read keeps ready", rd_val, 32'hC);
    rd(3);
    chk("R5 receive word", rd_val, 32'h1357_9BDF);
    rd(1);
    chk("R6 completed read clears ready", rd_val, 32'h4);
    wr(1, 32'h4);
    rd(1);
    chk("R7 receive interrupt cleared", rd_val, 32'h0);
    wait_cyc(1);
    chk("R9 irq_rx dropped", {31'd0, irq_rx}, 32'd0);
    wr(0, 32'h0);
  endtask

  task automatic t_collide();
    pulse_upd(32'h0000_0011);
    jt_rx_word = 32'h0000_0022;
    xfer(1'b0, 3, '0, 1'b1, 1'b0, 1'b0);
    chk("R8 read data before update", rd_val, 32'h0000_0011);
    rd(1);
    chk("R8 update beats read clear", rd_val, 32'hC);
    xfer(1'b1, 1, 32'h4, 1'b1, 1'b0, 1'b0);
    rd(1);
    chk("R8 update beats interrupt clear", rd_val, 32'hC);
    rd(3);
    wr(1, 32'h4);
    rd(1);
    chk("R8 receive side idle", rd_val, 32'h0);

    wr(2, 32'h0000_1111);
    xfer(1'b1, 2, 32'h0000_2222, 1'b0, 1'b1, 1'b0);
    rd(1);
    chk("R8 write beats capture clear", rd_val, 32'h3);
    chk("R3 new word exported", jt_tx_word, 32'h0000_2222);
    xfer(1'b1, 1, 32'h1, 1'b0, 1'b1, 1'b0);
    rd(1);
    chk("R8 capture beats interrupt clear", rd_val, 32'h1);
    wr(1, 32'h1);
    rd(1);
    chk("R8 transmit side idle", rd_val, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_handshake();
    t_map();
    t_tx_path();
    t_gate();
    t_rx_path();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule